// File: doc/BRIEF.md
# Bit-Serial Four-Bit Adder

This block adds two unsigned operands using one full adder that is reused once per clock. When a start request is accepted, both operands are copied into shift registers, and the carry flip-flop is cleared. Over the next W clocks, the lowest bit of each operand register goes into the full adder. Each sum bit is shifted into the top of a result register. The carry-out is held in a flip-flop and used as the carry-in for the next bit.

A single-cycle `done` pulse marks the end of a sequence. From that cycle on, `sum` and `cout` together hold the (W+1)-bit total. They keep that value until the next start is accepted. A start request raised while a sequence is running is ignored.

Top module: `bitser_add`

## Requirements
- R1: While `rst_n` is low and after it rises with no start, `sum` is 0, `cout` is 0 and `done` is 0.
- R2: A start sampled while idle loads both operands and clears the carry flip-flop. `cout` reads 0 in the cycle after that edge, even if the previous result had a carry of 1.
- R3: `done` is high for exactly one cycle. That cycle begins W clock edges after the edge that sampled the accepted start, and `done` is low in every other cycle.
- R4: While `done` is high, `sum` equals (opa + opb) mod 2^W, with bit 0 as the least significant result bit.
- R5: While `done` is high, `cout` equals bit W of opa + opb.
- R6: A start raised during a running sequence has no effect. The result and the timing of `done` are the same as without it.
- R7: While idle with no start, `sum` and `cout` keep their values.
- R8: Bits are processed least significant first. One edge after the load, `sum[W-1]` equals opa[0] XOR opb[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load request; accepted only while idle |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| sum | output | W | Result register, valid from `done` |
| cout | output | 1 | Carry flip-flop; final carry from `done` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs every operand pair back to back. In this order, a pair whose sum overflows is always followed by a fresh load. A design that failed to clear the carry on load would therefore add a stray 1 to the next result. On alternate pairs, a second start with different operands is raised in the middle of the sequence. A design that accepted it would produce the wrong total or a late `done`.

The bench also checks the first shifted bit and the exact done cycle. These catch a design that shifts in MSB-first order or runs one shift too many or too few. It also checks that the result holds in the cycle after `done`, which catches a design that keeps shifting when idle.

// File: rtl/bitser_add.sv
module bitser_add #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sa, sb;
  logic          carry, busy;
  logic [CW-1:0] cnt;
  logic          fs, fc;

  assign fs   = sa[0] ^ sb[0] ^ carry;
  assign fc   = (sa[0] & sb[0]) | (carry & (sa[0] ^ sb[0]));
  assign cout = carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa    <= '0;
      sb    <= '0;
      sum   <= '0;
      carry <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        sa    <= opa;
        sb    <= opb;
        carry <= 1'b0;
        cnt   <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        sa    <= sa >> 1;
        sb    <= sb >> 1;
        sum   <= {fs, sum[W-1:1]};
        carry <= fc;
        cnt   <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bitser_add_chk.sv
module bitser_add_chk #(
  parameter int W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic [$clog2(W+1)-1:0] cnt,
  input logic [W-1:0]           sum,
  input logic                   cout,
  input logic                   done
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!done && !cout && sum == '0)); // R1
  AST_LOAD_CLR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !cout); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != 1) |=> (busy && !done)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum) && $stable(cout))); // R7
endmodule

bind bitser_add bitser_add_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cnt(cnt),
  .sum(sum), .cout(cout), .done(done)
);

// File: tb/bitser_add_tb.sv
module bitser_add_tb;
  localparam int W = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] sum;
  logic cout, done;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bitser_add #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
    .sum(sum), .cout(cout), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int a, input int b, input bit inject);
    int tot = a + b;
    @(negedge clk); start = 1'b1; opa = W'(a); opb = W'(b);
    @(negedge clk); start = 1'b0; opa = ~opa; opb = ~opb;
    chk(cout == 1'b0, "R2 carry cleared on load", cout, 0);
    chk(done == 1'b0, "R3 done low after load", done, 0);
    @(negedge clk);
    chk(sum[W-1] == (a[0] ^ b[0]), "R8 lsb first", sum[W-1], a[0] ^ b[0]);
    if (inject) begin start = 1'b1; opa = W'(a + 5); opb = W'(b + 3); end
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R6 no early done", done, 0);
    for (int i = 3; i < W; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R3 done low mid", done, 0);
    end
    @(negedge clk);
    chk(done == 1'b1, "R3 done pulse", done, 1);
    chk(sum == W'(tot), "R4 sum", sum, tot % (1 << W));
    chk(cout == tot[W], "R5 cout", cout, tot[W]);
    @(negedge clk);
    chk(done == 1'b0, "R3 done one cycle", done, 0);
    chk(sum == W'(tot) && cout == tot[W], "R7 hold", {cout, sum}, tot);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sum == '0 && cout == 1'b0 && done == 1'b0, "R1 in reset", {done, cout, sum}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sum == '0 && cout == 1'b0 && done == 1'b0, "R1 after reset", {done, cout, sum}, 0);
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run(a, b, b[0]);
    run(15, 15, 1'b0);
    run(0, 0, 1'b1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule